// File: doc/BRIEF.md
# Converter Sample Test Pattern Generator

This block sits on each converter channel just ahead of the link transport layer. It either forwards the live converter sample, or replaces it with a synthetic 16-bit word. A 4-bit mode input selects which pattern is produced. Two shared 16-bit custom words supply user values for the modes that need them.

In every test mode the pattern fills the upper 14 bits of the sample, and the two least significant bits are forced to zero. Sequenced patterns restart from their first value whenever the mode input changes. These patterns are the alternating words, the ramp, the custom pair, the sine table and the pseudo-random sequence. Because of this, a receiver can predict the stream from the moment the mode is written. One sample leaves the block per sample clock, through a single output register.

Top module: `sample_pattern_gen`

## Requirements
- R1: While `rst_n` is low the output `smp_out` is 0000h.
- R2: With mode 0000 the output equals `raw_in` from one clock earlier, unchanged in all 16 bits; every other result also appears one clock after the inputs that produce it.
- R3: In every mode other than 0000, bits [1:0] of `smp_out` are 00; mode 0001 gives 0000h and mode 0010 gives FFFCh.
- R4: Mode 0011 gives pattern word 10101010101010 on the first sample after entry, then alternates each clock with 01010101010101 (FFFC-masked outputs AAA8h and 5554h).
- R5: Mode 0100 gives a ramp whose pattern value is floor(n/4), where n counts samples from entry starting at 0. The ramp wraps from 16383 to 0, and any mode change restarts n at 0.
- R6: Mode 0110 outputs `cust_a[15:2]` in the pattern bits, following live changes of `cust_a`.
- R7: Mode 0111 outputs `cust_a[15:2]` on even n and `cust_b[15:2]` on odd n, with n counted from entry.
- R8: Mode 1000 outputs the fixed word AAA8h.
- R9: Mode 1010 runs a 15-bit LFSR s, seeded to 7FFFh on entry, with next state {s[13:0], s[14]^s[13]} (polynomial x^15+x^14+1). The pattern bits are s[14:1] of the current state.
- R10: Mode 1011 cycles the pattern values 0, 2399, 8192, 13984, 16383, 13984, 8192, 2399, starting at 0 on entry.
- R11: Reserved modes 0101, 1001, 1100, 1101, 1110 and 1111 output 0000h regardless of `raw_in` and the custom words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| mode_sel | input | 4 | Pattern selection code |
| cust_a | input | 16 | First shared custom word |
| cust_b | input | 16 | Second shared custom word |
| raw_in | input | 16 | Live converter sample |
| smp_out | output | 16 | Sample toward the transport layer |

## Verification
Every result is due exactly one clock after the rising edge that sampled the mode, the custom words and the live sample. There is one output register and no other latency. The bench drives inputs on the falling edge. It advances its own model of the sequence index and LFSR by one step per rising edge, and compares on the following falling edge. Mode entry counts as index 0 on the first edge at which the new code is seen. So restart behaviour is checked in the cycle right after each mode switch, and ramp wrap is checked 65536 samples after entry.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [3:0] {
    PM_LIVE   = 4'h0,
    PM_ZERO   = 4'h1,
    PM_ONES   = 4'h2,
    PM_TOGGLE = 4'h3,
    PM_RAMP   = 4'h4,
    PM_FIXED  = 4'h6,
    PM_PAIR   = 4'h7,
    PM_DESKEW = 4'h8,
    PM_PRBS   = 4'hA,
    PM_SINE   = 4'hB
  } pat_mode_e;

  localparam int unsigned SINE_W = 14;

  // eight-point sine, 14-bit unsigned amplitude
  function automatic logic [SINE_W-1:0] sine_point(input logic [2:0] ph);
    logic [SINE_W-1:0] v;
    case (ph)
      3'd0:    v = 14'd0;
      3'd1:    v = 14'd2399;
      3'd2:    v = 14'd8192;
      3'd3:    v = 14'd13984;
      3'd4:    v = 14'd16383;
      3'd5:    v = 14'd13984;
      3'd6:    v = 14'd8192;
      default: v = 14'd2399;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tpg_phase.sv
module tpg_phase #(
  parameter int unsigned MODE_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              restart,
  output logic [CNT_W-1:0]  idx
);

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    restart = (mode_sel != mode_q);
    idx     = restart ? '0 : cnt_q;
    cnt_d   = idx + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_sel;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/tpg_prbs.sv
module tpg_prbs #(
  parameter int unsigned   W    = 15,
  parameter int unsigned   TAP  = 14,
  parameter logic [W-1:0]  SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  output logic [W-1:0] state
);

  logic [W-1:0] lfsr_q;
  logic [W-1:0] lfsr_d;
  logic         fb;

  always_comb begin
    state  = restart ? SEED : lfsr_q;
    fb     = state[W-1] ^ state[TAP-1];
    lfsr_d = {state[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
    end else if (run) begin
      lfsr_q <= lfsr_d;
    end
  end

endmodule

// File: rtl/sample_pattern_gen.sv
module sample_pattern_gen #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned PAD_W     = 2,
  parameter int unsigned RAMP_LOG2 = 2,
  parameter int unsigned LFSR_W    = 15,
  parameter int unsigned LFSR_TAP  = 14,
  parameter logic [SAMPLE_W-1:0] DESKEW_WORD = 16'hAAA8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          mode_sel,
  input  logic [SAMPLE_W-1:0] cust_a,
  input  logic [SAMPLE_W-1:0] cust_b,
  input  logic [SAMPLE_W-1:0] raw_in,
  output logic [SAMPLE_W-1:0] smp_out
);
  import tpg_pkg::*;

  localparam int unsigned PAT_W = SAMPLE_W - PAD_W;
  localparam int unsigned CNT_W = PAT_W + RAMP_LOG2;

  logic              restart;
  logic [CNT_W-1:0]  idx;
  logic [LFSR_W-1:0] prbs_state;
  logic              prbs_run;
  logic [PAT_W-1:0]  tog_even;
  logic [PAT_W-1:0]  sine_val;
  logic [SINE_W-1:0] sine_raw;
  logic [PAT_W-1:0]  pat;
  logic [SAMPLE_W-1:0] smp_d;
  logic [SAMPLE_W-1:0] smp_q;
  pat_mode_e         mode;

  assign mode     = pat_mode_e'(mode_sel);
  assign prbs_run = (mode == PM_PRBS);

  tpg_phase #(
    .MODE_W (4),
    .CNT_W  (CNT_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .restart  (restart),
    .idx      (idx)
  );

  tpg_prbs #(
    .W    (LFSR_W),
    .TAP  (LFSR_TAP),
    .SEED ({LFSR_W{1'b1}})
  ) u_prbs (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (prbs_run),
    .restart (restart),
    .state   (prbs_state)
  );

  // alternating word: odd bit positions set, top bit first
  for (genvar b = 0; b < PAT_W; b++) begin : g_tog
    assign tog_even[b] = (b % 2) == 1;
  end

  assign sine_raw = sine_point(idx[2:0]);

  if (PAT_W == SINE_W) begin : g_sine_eq
    assign sine_val = sine_raw;
  end else if (PAT_W > SINE_W) begin : g_sine_wide
    assign sine_val = {sine_raw, {(PAT_W-SINE_W){1'b0}}};
  end else begin : g_sine_narrow
    assign sine_val = sine_raw[SINE_W-1 -: PAT_W];
  end

  always_comb begin
    case (mode)
      PM_ZERO:   pat = '0;
      PM_ONES:   pat = '1;
      PM_TOGGLE: pat = idx[0] ? ~tog_even : tog_even;
      PM_RAMP:   pat = idx[CNT_W-1 -: PAT_W];
      PM_FIXED:  pat = cust_a[SAMPLE_W-1 -: PAT_W];
      PM_PAIR:   pat = idx[0] ? cust_b[SAMPLE_W-1 -: PAT_W]
                              : cust_a[SAMPLE_W-1 -: PAT_W];
      PM_DESKEW: pat = DESKEW_WORD[SAMPLE_W-1 -: PAT_W];
      PM_PRBS:   pat = prbs_state[LFSR_W-1 -: PAT_W];
      PM_SINE:   pat = sine_val;
      default:   pat = '0;
    endcase
    if (mode == PM_LIVE) begin
      smp_d = raw_in;
    end else begin
      smp_d = {pat, {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
    end else begin
      smp_q <= smp_d;
    end
  end

  assign smp_out = smp_q;

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  mode_sel,
  input logic [15:0] raw_in,
  input logic [15:0] smp_out
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> smp_out == 16'h0000);

  assert_live_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(mode_sel) == 4'h0) |-> smp_out == $past(raw_in));

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(mode_sel) != 4'h0) |-> smp_out[1:0] == 2'b00);

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(mode_sel) == 4'h3 && $past(mode_sel, 2) == 4'h3)
      |-> smp_out[15:2] == ~$past(smp_out[15:2]));

  assert_ramp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(mode_sel) == 4'h4 && $past(mode_sel, 2) == 4'h4)
      |-> 14'(smp_out[15:2] - $past(smp_out[15:2])) <= 14'd1);

  assert_deskew_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(mode_sel) == 4'h8) |-> smp_out == 16'hAAA8);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && ($past(mode_sel) == 4'h5 || $past(mode_sel) == 4'h9 ||
                     $past(mode_sel[3:2]) == 2'b11)) |-> smp_out == 16'h0000);

endmodule

bind sample_pattern_gen tpg_checker i_tpg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .raw_in   (raw_in),
  .smp_out  (smp_out)
);

// File: tb/test_sample_pattern_gen.sv
module test_sample_pattern_gen;

  logic        clk;
  logic        rst_n;
  logic [3:0]  mode_sel;
  logic [15:0] cust_a;
  logic [15:0] cust_b;
  logic [15:0] raw_in;
  logic [15:0] smp_out;

  int n_chk;
  int n_err;
  int cyc;

  // bench model state
  logic [3:0]  m_prev;
  logic [15:0] m_cnt;
  logic [14:0] m_lfsr;

  sample_pattern_gen i_sample_pattern_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .cust_a   (cust_a),
    .cust_b   (cust_b),
    .raw_in   (raw_in),
    .smp_out  (smp_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [13:0] sine_ref(input int k);
    int t [8] = '{0, 2399, 8192, 13984, 16383, 13984, 8192, 2399};
    return 14'(t[k % 8]);
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    n_chk++;
    if (smp_out !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, smp_out, exp, cyc);
    end
  endtask

  // drive one sample at a falling edge, check it one clock later
  task automatic drive(input string tag, input logic [3:0] md,
                       input logic [15:0] r, input logic [15:0] a,
                       input logic [15:0] b);
    logic        rs;
    logic [15:0] ix;
    logic [14:0] lc;
    logic [13:0] p;
    logic [15:0] exp;
    mode_sel = md; raw_in = r; cust_a = a; cust_b = b;
    rs = (md != m_prev);
    ix = rs ? 16'd0 : m_cnt;
    lc = rs ? 15'h7FFF : m_lfsr;
    case (md)
      4'h1: p = 14'h0000;
      4'h2: p = 14'h3FFF;
      4'h3: p = ix[0] ? 14'b01010101010101 : 14'b10101010101010;
      4'h4: p = ix[15:2];
      4'h6: p = a[15:2];
      4'h7: p = ix[0] ? b[15:2] : a[15:2];
      4'h8: p = 14'h2AAA;
      4'hA: p = lc[14:1];
      4'hB: p = sine_ref(int'(ix[2:0]));
      default: p = 14'h0000;
    endcase
    exp = (md == 4'h0) ? r : {p, 2'b00};
    m_cnt = ix + 16'd1;
    if (md == 4'hA) m_lfsr = {lc[13:0], lc[14] ^ lc[13]};
    m_prev = md;
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; cyc = 0;
    rst_n = 1'b0; mode_sel = 4'h0; cust_a = 16'h1234; cust_b = 16'hBEEF;
    raw_in = 16'hFFFF;
    m_prev = 4'h0; m_cnt = 16'd0; m_lfsr = 15'h7FFF;
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0000);
    mode_sel = 4'h2;
    @(negedge clk);
    check("R1 reset held", 16'h0000);
    mode_sel = 4'h0;
    rst_n = 1'b1;

    // R2 live data, one clock latency
    for (int i = 0; i < 24; i++)
      drive("R2 live", 4'h0, 16'((i * 16'h2F1D) ^ 16'hA5C3), 16'h1234, 16'hBEEF);

    // R3 constant modes and padding
    for (int i = 0; i < 4; i++) drive("R3 zeros", 4'h1, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    for (int i = 0; i < 4; i++) drive("R3 ones", 4'h2, 16'h0000, 16'h0000, 16'h0000);

    // R4 toggle
    for (int i = 0; i < 7; i++) drive("R4 toggle", 4'h3, 16'h0F0F, 16'h1234, 16'hBEEF);

    // R5 ramp, restart on change
    for (int i = 0; i < 22; i++) drive("R5 ramp", 4'h4, 16'h0000, 16'h1234, 16'hBEEF);
    drive("R5 leave", 4'h1, 16'h0000, 16'h1234, 16'hBEEF);
    for (int i = 0; i < 9; i++) drive("R5 ramp restart", 4'h4, 16'h0000, 16'h1234, 16'hBEEF);

    // R6 single custom word, live update
    for (int i = 0; i < 8; i++)
      drive("R6 custom", 4'h6, 16'h5555, 16'(16'h8001 + i * 16'h1357), 16'hBEEF);

    // R7 custom pair
    for (int i = 0; i < 8; i++) drive("R7 pair", 4'h7, 16'h0000, 16'hC3A7, 16'h1E5B);

    // R8 deskew
    for (int i = 0; i < 4; i++) drive("R8 deskew", 4'h8, 16'h1111, 16'h2222, 16'h3333);

    // R9 PRBS, then re-entry reseeds
    for (int i = 0; i < 40; i++) drive("R9 prbs", 4'hA, 16'h0000, 16'h1234, 16'hBEEF);
    drive("R9 leave", 4'h8, 16'h0000, 16'h1234, 16'hBEEF);
    for (int i = 0; i < 6; i++) drive("R9 prbs reseed", 4'hA, 16'h0000, 16'h1234, 16'hBEEF);

    // R10 sine
    for (int i = 0; i < 20; i++) drive("R10 sine", 4'hB, 16'hFFFF, 16'h1234, 16'hBEEF);

    // R11 reserved codes
    for (int c = 12; c < 16; c++) drive("R11 reserved", 4'(c), 16'hFFFF, 16'hFFFF, 16'hFFFF);
    drive("R11 reserved 5", 4'h5, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    drive("R11 reserved 9", 4'h9, 16'hFFFF, 16'hFFFF, 16'hFFFF);

    // R5 full ramp sweep through wrap
    for (int i = 0; i < 65544; i++) drive("R5 ramp wrap", 4'h4, 16'h0000, 16'h0000, 16'h0000);

    drive("R2 live return", 4'h0, 16'h7E81, 16'h0000, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule